// File: doc/BRIEF.md
# I2C Step-Commanded Bus Master

This block is a single-master I2C controller that a CPU drives one byte phase at a time over a small register bus. Software loads an address byte, made of a 7-bit slave address with the direction bit in bit 0, and a transmit byte. It then writes a command to start, repeat-start, send a byte, receive a byte or stop. Each byte phase ends with an acknowledge slot. The controller then parks in a wait state with SCL held low and raises its interrupt. From there the CPU reads the acknowledge flag and the byte that appeared on the wire, and chooses the next step.

The SCL and SDA outputs are open-drain enables: 1 pulls the line low and 0 releases it. SDA is read back through a two-flop synchroniser. Each bit slot lasts four quarters of DIV+1 clock cycles each. SCL is low in quarters 0 and 3 and high in quarters 1 and 2. SDA changes only at quarter 0, and SDA is sampled at the end of quarter 1. The register bus has a write strobe with address and data, and a combinational read port. A byte phase moves at most one byte and cannot be stalled, so there is no valid/ready stream at the edge. The CPU is paced by the interrupt and the wait state instead, and SCL is held low (back-pressure toward the slave) until the next command arrives.

The registers are selected by `reg_addr`:

- 0, command/control. Write: bit0 GO, bit1 RS, bit2 STOP, bit3 RX, bit7 ACKSEL. Read: bit0 busy, bit3 RX, bit7 ACKSEL.
- 1, address byte, read/write.
- 2, transmit byte, read/write.
- 3, status. Read: bit0 interrupt flag, bit1 acknowledge flag, bit2 waiting. Write: 1 in bit0 clears the interrupt flag.
- 4, received byte, read-only.
- 5, configuration. Bit0 EN, read/write.
- 6, divider DIV, read/write.

Top module: `i2c_step_master`

## Requirements
- R1: After reset both lines are released and `irq` is 0. Registers 0, 1, 2, 3, 4 and 5 read 0, and register 6 reads DIV_RST (3).
- R2: With EN=1 and the controller idle (busy=0), writing GO=1 to register 0 produces a start condition: SDA falls while SCL is high. The address byte then goes out MSB first in 8 bit slots, followed by an acknowledge slot.
- R3: At the end of the acknowledge slot, status bit1 holds the sampled SDA level: 0 for ACK, 1 for NACK.
- R4: After an address or transmit phase, register 4 reads the byte that was on the wire.
- R5: A command with GO=1 and RX=1 issued in the wait state samples 8 bits from SDA. In the acknowledge slot it drives ACKSEL (0 pulls SDA low, 1 releases it). Register 4 then reads the received byte and status bit1 reads ACKSEL.
- R6: The acknowledge slot ends DIV+1 cycles after its SCL falling edge. At that point the controller enters the wait state: `irq` and status bits 0 and 2 become 1, and SCL stays low until an accepted command.
- R7: GO=1 with RS=1 in the wait state produces a repeated start condition, then an address phase that uses register 1.
- R8: STOP=1 in the wait state produces a stop condition, in which SDA rises while SCL is high. The controller then returns to idle with busy=0 and both lines released.
- R9: Any accepted command clears the interrupt flag, and so does writing 1 to status bit0. Writing 0 to status bit0 leaves the flag unchanged.
- R10: Writes to register 0 during a start, byte or stop sequence are ignored. The phase completes normally, and no stop condition is produced.
- R11: Consecutive SCL rising edges inside a byte are 4*(DIV+1) cycles apart.
- R12: EN=0 returns the controller to idle within one cycle, releases both lines and clears the interrupt flag. GO is ignored while EN=0.
- R13: During bit slots, SDA changes only while SCL is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Wait-state interrupt flag |

## Verification
A command takes effect on the clock edge that registers it, and register reads are combinational, so every read is sampled one time step after a falling clock edge. The interrupt is due exactly DIV+1 cycles after the acknowledge slot's SCL fall. The bench therefore checks it low one half-cycle after that fall and high DIV+1 cycles later. A stop completes 4*(DIV+1) cycles after its command write, and the bench checks idle a few cycles beyond that. Disable takes effect one cycle after the configuration write, and the line release is checked on the next falling edge.

// File: rtl/i2c_step_pkg.sv
package i2c_step_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_RSTART, ST_BITS, ST_STOP, ST_WAIT
  } step_st_t;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_ADDR = 3'd1;
  localparam logic [2:0] RA_TXD  = 3'd2;
  localparam logic [2:0] RA_STAT = 3'd3;
  localparam logic [2:0] RA_RXD  = 3'd4;
  localparam logic [2:0] RA_CFG  = 3'd5;
  localparam logic [2:0] RA_DIV  = 3'd6;
endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_step_regs.sv
module i2c_step_regs
  import i2c_step_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             cmd_ok,
  input  logic             busy,
  input  logic             waiting,
  input  logic             irq,
  input  logic             ackf,
  input  logic [7:0]       rxd,
  output logic             cmd_vld,
  output logic             irq_clr,
  output logic [7:0]       sa,
  output logic [7:0]       td,
  output logic             en,
  output logic             acksel_q,
  output logic [DIV_W-1:0] div
);
  logic       rx_q;
  logic [7:0] div_rb;

  assign cmd_vld = reg_wr && (reg_addr == RA_CTRL);
  assign irq_clr = reg_wr && (reg_addr == RA_STAT) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa       <= '0;
      td       <= '0;
      en       <= 1'b0;
      div      <= DIV_W'(DIV_RST);
      acksel_q <= 1'b0;
      rx_q     <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_ADDR: sa  <= reg_wdata;
          RA_TXD:  td  <= reg_wdata;
          RA_CFG:  en  <= reg_wdata[0];
          RA_DIV:  div <= reg_wdata[DIV_W-1:0];
          default: ;
        endcase
      end
      if (cmd_ok) begin
        acksel_q <= reg_wdata[7];
        rx_q     <= reg_wdata[3];
      end
    end
  end

  always_comb begin
    div_rb = '0;
    div_rb[DIV_W-1:0] = div;
    case (reg_addr)
      RA_CTRL: reg_rdata = {acksel_q, 3'b000, rx_q, 2'b00, busy};
      RA_ADDR: reg_rdata = sa;
      RA_TXD:  reg_rdata = td;
      RA_STAT: reg_rdata = {5'b00000, waiting, ackf, irq};
      RA_RXD:  reg_rdata = rxd;
      RA_CFG:  reg_rdata = {7'b0000000, en};
      RA_DIV:  reg_rdata = div_rb;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_step_engine.sv
module i2c_step_engine
  import i2c_step_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       cmd_vld,
  input  logic       cmd_go,
  input  logic       cmd_rs,
  input  logic       cmd_stop,
  input  logic       cmd_rx,
  input  logic       acksel,
  input  logic       irq_clr,
  input  logic [7:0] sa,
  input  logic [7:0] td,
  input  logic       sda_s,
  output step_st_t   st,
  output logic       run,
  output logic       cmd_ok,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rxd,
  output logic       ackf,
  output logic       irq
);
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] tx_sh, rx_sh;
  logic       rx_mode;
  logic       scl_rel, sda_rel;
  logic       ack_slot;

  assign ack_slot = (bitn == 4'd8);
  assign run = (st == ST_START) || (st == ST_RSTART) || (st == ST_BITS) || (st == ST_STOP);

  always_comb begin
    cmd_ok = 1'b0;
    if (cmd_vld && en) begin
      if (st == ST_IDLE)      cmd_ok = cmd_go && !cmd_stop;
      else if (st == ST_WAIT) cmd_ok = cmd_go || cmd_stop;
    end
  end

  always_comb begin
    scl_rel = 1'b1;
    sda_rel = 1'b1;
    case (st)
      ST_START:  begin scl_rel = (q != 2'd3); sda_rel = (q == 2'd0); end
      ST_RSTART: begin scl_rel = (q == 2'd1) || (q == 2'd2); sda_rel = (q < 2'd2); end
      ST_BITS: begin
        scl_rel = (q == 2'd1) || (q == 2'd2);
        if (ack_slot) sda_rel = rx_mode ? acksel : 1'b1;
        else          sda_rel = rx_mode ? 1'b1 : tx_sh[7];
      end
      ST_STOP:   begin scl_rel = (q != 2'd0); sda_rel = (q == 2'd3); end
      ST_WAIT:   begin scl_rel = 1'b0; sda_rel = 1'b1; end
      default: ;
    endcase
  end

  assign scl_oe = !scl_rel;
  assign sda_oe = !sda_rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      q       <= '0;
      bitn    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_mode <= 1'b0;
      rxd     <= '0;
      ackf    <= 1'b0;
      irq     <= 1'b0;
    end else if (!en) begin
      st  <= ST_IDLE;
      q   <= '0;
      irq <= 1'b0;
    end else begin
      if (cmd_ok || irq_clr) irq <= 1'b0;
      if (cmd_ok) begin
        q    <= '0;
        bitn <= '0;
        if (st == ST_IDLE) begin
          st <= ST_START; tx_sh <= sa; rx_mode <= 1'b0;
        end else if (cmd_stop) begin
          st <= ST_STOP;
        end else if (cmd_rs) begin
          st <= ST_RSTART; tx_sh <= sa; rx_mode <= 1'b0;
        end else begin
          st <= ST_BITS; tx_sh <= td; rx_mode <= cmd_rx;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (st)
          ST_START, ST_RSTART: if (q == 2'd3) st <= ST_BITS;
          ST_STOP:             if (q == 2'd3) st <= ST_IDLE;
          ST_BITS: begin
            if (q == 2'd1) begin
              if (ack_slot) ackf  <= sda_s;
              else          rx_sh <= {rx_sh[6:0], sda_s};
            end
            if (q == 2'd3) begin
              if (ack_slot) begin
                st  <= ST_WAIT;
                rxd <= rx_sh;
                irq <= 1'b1;
              end else begin
                bitn  <= bitn + 4'd1;
                tx_sh <= {tx_sh[6:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
  import i2c_step_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_RST = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);
  step_st_t         st;
  logic             run, tick, cmd_ok, cmd_vld, irq_clr, en, acksel_q, ackf, sda_s;
  logic [7:0]       sa, td, rxd;
  logic [DIV_W-1:0] div;
  logic [1:0]       sda_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) sda_sync <= 2'b11;
    else        sda_sync <= {sda_sync[0], sda_in};
  end
  assign sda_s = sda_sync[1];

  i2c_step_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_ok(cmd_ok),
    .busy(st != ST_IDLE), .waiting(st == ST_WAIT), .irq(irq), .ackf(ackf),
    .rxd(rxd), .cmd_vld(cmd_vld), .irq_clr(irq_clr), .sa(sa), .td(td),
    .en(en), .acksel_q(acksel_q), .div(div)
  );

  i2c_qtick #(.DIV_W(DIV_W)) u_qtick (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
  );

  i2c_step_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .cmd_vld(cmd_vld),
    .cmd_go(reg_wdata[0]), .cmd_rs(reg_wdata[1]), .cmd_stop(reg_wdata[2]),
    .cmd_rx(reg_wdata[3]), .acksel(acksel_q), .irq_clr(irq_clr),
    .sa(sa), .td(td), .sda_s(sda_s), .st(st), .run(run), .cmd_ok(cmd_ok),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rxd(rxd), .ackf(ackf), .irq(irq)
  );
endmodule

// File: rtl/i2c_step_master_chk.sv
module i2c_step_master_chk
  import i2c_step_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input step_st_t st,
  input logic     en,
  input logic     scl_oe,
  input logic     sda_oe,
  input logic     irq
);
  // R12
  release_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe));

  // R13
  sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BITS && $past(st) == ST_BITS && sda_oe != $past(sda_oe))
      |-> (scl_oe && $past(scl_oe)));

  // R6
  irq_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (st == ST_WAIT));

  // R6
  wait_holds_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_oe);

  // R10
  phase_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_BITS && st != ST_BITS) |-> (st == ST_WAIT || st == ST_IDLE));

  // R8
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_STOP && st != ST_STOP) |-> (st == ST_IDLE));
endmodule

bind i2c_step_master i2c_step_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .en(en),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
);

// File: tb/i2c_step_master_bench.sv
module i2c_step_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       slave_low = 1'b0;
  wire  [7:0] reg_rdata;
  wire        scl_oe, sda_oe, irq;
  wire        scl_w = ~scl_oe;
  wire        sda_w = ~(sda_oe | slave_low);

  i2c_step_master u_i2c_step_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0, starts = 0, stops = 0, cur_div = 3;
  time t_rise0, t_rise1;
  logic [7:0] wire_byte;

  // kind, data, flag (slave NACK or ACKSEL), expected RXD, expected ack flag
  localparam logic [20:0] VEC [9] = '{
    {3'd1, 8'hA4, 1'b0, 8'hA4, 1'b0},
    {3'd2, 8'h3C, 1'b0, 8'h3C, 1'b0},
    {3'd2, 8'hFF, 1'b1, 8'hFF, 1'b1},
    {3'd4, 8'hA5, 1'b0, 8'hA5, 1'b0},
    {3'd3, 8'h5A, 1'b0, 8'h5A, 1'b0},
    {3'd3, 8'h81, 1'b1, 8'h81, 1'b1},
    {3'd5, 8'h00, 1'b0, 8'h00, 1'b0},
    {3'd1, 8'h10, 1'b1, 8'h10, 1'b1},
    {3'd5, 8'h00, 1'b0, 8'h00, 1'b0}
  };

  always @(negedge sda_w) if (scl_w === 1'b1) starts++;
  always @(posedge sda_w) if (scl_w === 1'b1) stops++;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic phase(input logic [7:0] ctrl, input logic [8:0] slv, input bit pre, input bit mid_stop);
    wr(3'd0, ctrl);
    check("R9 irq cleared by command", irq, 0);
    if (pre) @(negedge scl_w);
    wire_byte = 8'h00;
    for (int i = 0; i < 9; i++) begin
      slave_low = slv[8-i];
      @(posedge scl_w);
      if (i == 0) t_rise0 = $time;
      if (i == 1) t_rise1 = $time;
      if (i < 8) wire_byte = {wire_byte[6:0], sda_w};
      if (mid_stop && i == 3) wr(3'd0, 8'h04);
      @(negedge scl_w);
    end
    slave_low = 1'b0;
  endtask

  task automatic after_byte(input string tg, input logic [7:0] exp_rd, input logic exp_ack);
    logic [7:0] v;
    @(negedge clk);
    check("R6 irq low until slot ends", irq, 0);
    repeat (cur_div + 1) @(negedge clk);
    check("R6 irq set on wait", irq, 1);
    rd(3'd3, v);
    check("R6 status irq and waiting", {29'd0, v[2:0] & 3'b101}, 32'd5);
    check("R3 ack flag", v[1], exp_ack);
    rd(3'd4, v);
    check(tg, v, exp_rd);
    repeat (20) @(negedge clk);
    check("R6 scl held low in wait", scl_w, 0);
  endtask

  task automatic do_stop();
    int s0;
    logic [7:0] v;
    s0 = stops;
    wr(3'd0, 8'h04);
    repeat (4 * (cur_div + 1) + 3) @(negedge clk);
    check("R8 stop condition seen", stops, s0 + 1);
    rd(3'd0, v);
    check("R8 busy clear", v[0], 0);
    check("R8 lines released", {scl_w, sda_w}, 2'b11);
    check("R9 irq clear after stop", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    int s0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 register reset value", v, 0);
    end
    rd(3'd6, v);
    check("R1 divider reset value", v, 3);
    check("R1 irq low", irq, 0);
    check("R1 lines released", {scl_w, sda_w}, 2'b11);

    // R12 GO ignored while disabled
    s0 = starts;
    wr(3'd1, 8'h66);
    wr(3'd0, 8'h01);
    repeat (40) @(negedge clk);
    rd(3'd0, v);
    check("R12 no transfer while disabled", v[0], 0);
    check("R12 no start while disabled", starts, s0);

    wr(3'd5, 8'h01);

    for (int k = 0; k < 9; k++) begin
      logic [2:0] kind;
      logic [7:0] dat, erd;
      logic       flg, eack;
      {kind, dat, flg, erd, eack} = VEC[k];
      case (kind)
        3'd1: begin
          s0 = starts;
          wr(3'd1, dat);
          phase(8'h01, {8'h00, ~flg}, 1'b1, 1'b0);
          check("R2 start condition", starts, s0 + 1);
          check("R2 address MSB first on wire", wire_byte, dat);
          if (k == 0) check("R11 bit period at DIV 3", 32'((t_rise1 - t_rise0) / 8), 16);
          after_byte("R4 rxd after address", erd, eack);
        end
        3'd2: begin
          wr(3'd2, dat);
          phase(8'h01, {8'h00, ~flg}, 1'b0, 1'b0);
          check("R4 tx byte on wire", wire_byte, dat);
          after_byte("R4 rxd after transmit", erd, eack);
        end
        3'd3: begin
          phase(8'h09 | {flg, 7'b0}, {~dat, 1'b0}, 1'b0, 1'b0);
          after_byte("R5 rxd after receive", erd, eack);
        end
        3'd4: begin
          s0 = starts;
          wr(3'd1, dat);
          phase(8'h03, {8'h00, ~flg}, 1'b1, 1'b0);
          check("R7 repeated start seen", starts, s0 + 1);
          check("R7 new address on wire", wire_byte, dat);
          after_byte("R7 rxd after repeated start", erd, eack);
        end
        default: do_stop();
      endcase
    end

    // R10 stop written mid-byte is ignored
    wr(3'd1, 8'h22);
    s0 = stops;
    phase(8'h01, 9'h001, 1'b1, 1'b1);
    after_byte("R10 rxd unaffected by mid-byte write", 8'h22, 0);
    check("R10 no stop during byte", stops, s0);
    rd(3'd0, v);
    check("R10 still busy", v[0], 1);
    do_stop();

    // R9 write-1-to-clear of the interrupt flag
    wr(3'd1, 8'h30);
    phase(8'h01, 9'h001, 1'b1, 1'b0);
    after_byte("R4 rxd before clear test", 8'h30, 0);
    wr(3'd3, 8'h00);
    check("R9 zero write keeps irq", irq, 1);
    wr(3'd3, 8'h01);
    check("R9 w1c clears irq", irq, 0);
    rd(3'd3, v);
    check("R9 still waiting after clear", v[2], 1);
    check("R9 scl still low after clear", scl_w, 0);
    do_stop();

    // R11 divider change
    wr(3'd6, 8'h01);
    cur_div = 1;
    wr(3'd1, 8'h44);
    phase(8'h01, 9'h001, 1'b1, 1'b0);
    check("R11 bit period at DIV 1", 32'((t_rise1 - t_rise0) / 8), 8);
    after_byte("R4 rxd at DIV 1", 8'h44, 0);
    do_stop();

    // R12 disable in the middle of a byte
    wr(3'd1, 8'h55);
    wr(3'd0, 8'h01);
    repeat (10) @(negedge clk);
    wr(3'd5, 8'h00);
    @(negedge clk);
    check("R12 lines released on disable", {scl_w, sda_w}, 2'b11);
    check("R12 irq low on disable", irq, 0);
    rd(3'd0, v);
    check("R12 idle after disable", v[0], 0);

    summary();
    $finish;
  end
endmodule